// File: doc/BRIEF.md
# MIDI Host Port with Command Protocol

This block is the host-facing side of a byte-wide MIDI port. The host sees two byte locations chosen by a select line: a data location, and a shared location where commands are written and the status byte is read back. Two commands are recognised: one returns the port to its idle command mode, and one switches it into a pass-through (UART) mode. Each recognised command is answered with an acknowledge byte that the host reads from the data location like any received byte. Every other command byte is dropped.

In UART mode, bytes written to the data location are held in a transmit buffer and presented on the line side with a valid/ready handshake. Bytes arriving from the line with a valid strobe go into a receive buffer that the host drains by reading the data location. Two status flags are active-low: one for read data waiting, one for the data location being able to take a write. Two interrupt requests, each gated by its own enable input, signal an empty transmit buffer and a non-empty receive buffer. Serial bit framing is handled elsewhere.

Top module: `midi_port`

## Requirements
- R1: After reset the port is in command mode, the status byte reads 0x80, `tx_valid` is 0 and both interrupt outputs are 0.
- R2: Writing 0xFF to the command location (`host_sel`=1) returns the port to command mode, empties the transmit and receive buffers, and then leaves exactly one byte, 0xFE, in the receive buffer; this applies from either mode.
- R3: Writing 0x3F to the command location enters UART mode and places 0xFE in the receive buffer; a repeated 0x3F in UART mode queues 0xFE again, keeps UART mode and does not empty the transmit buffer.
- R4: A command byte other than 0xFF and 0x3F changes neither the mode nor either buffer and queues no acknowledge.
- R5: In command mode, writes to the data location (`host_sel`=0) are discarded and `tx_valid` stays 0.
- R6: In UART mode, bytes written to the data location appear on `tx_byte` with `tx_valid`=1 in write order; a byte leaves the buffer on a clock edge where `tx_valid` and `tx_ready` are both 1.
- R7: Status bit 6 is 1 while the transmit buffer is full (TX_DEPTH entries, default 2) and 0 otherwise; a data write while it is full is dropped.
- R8: In UART mode a byte on `rx_byte` with `rx_valid`=1 enters the receive buffer; a read of the data location (`host_rd`=1, `host_sel`=0) returns the oldest byte and removes it. In command mode line bytes are ignored.
- R9: When the receive buffer is full (RX_DEPTH entries, default 1), a newly arriving byte is dropped and the unread byte is kept.
- R10: Status bit 7 is 0 while the receive buffer holds at least one byte and 1 when it is empty; status bits 5..0 read 0. The status byte is read combinationally at the command location.
- R11: `irq_tx_empty` equals `tx_irq_en` AND UART mode AND transmit buffer empty; `irq_rx_level` equals `rx_irq_en` AND receive buffer non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 = data location, 1 = command/status location |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; pops the receive buffer when host_sel is 0 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or oldest received byte (0 when empty) |
| tx_byte | output | 8 | Byte offered to the line transmitter |
| tx_valid | output | 1 | Transmit buffer holds a byte |
| tx_ready | input | 1 | Line transmitter takes the offered byte |
| rx_byte | input | 8 | Byte from the line receiver |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| tx_irq_en | input | 1 | Enable for the transmit-empty request |
| rx_irq_en | input | 1 | Enable for the receive request |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_level | output | 1 | Receive-data interrupt request |

## Verification
The bench aims at the mode-dependent paths: a data write before UART mode is entered (a port that accepted it would raise `tx_valid`), an unknown command (a port that decoded too loosely would queue an acknowledge or change mode), and a reset command issued with transmit bytes pending (a port that failed to flush would keep sending them). It fills the transmit buffer with the line stalled and writes once more, so a port that overwrote instead of dropping would send the wrong byte sequence. It sends two line bytes into a one-entry receive buffer, where a port that let the newer byte win would return the second byte on the host read, and it toggles the interrupt enables with the buffers in known states.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;

   typedef enum logic {
      MODE_CMD  = 1'b0,
      MODE_UART = 1'b1
   } port_mode_e;

   localparam logic [7:0] CMD_RESET = 8'hFF;
   localparam logic [7:0] CMD_UART  = 8'h3F;
   localparam logic [7:0] ACK_BYTE  = 8'hFE;

   localparam int STAT_RX_EMPTY_BIT = 7;
   localparam int STAT_TX_FULL_BIT  = 6;

endpackage

// File: rtl/midi_hold_buf.sv
module midi_hold_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("midi_hold_buf: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("midi_hold_buf: W must be at least 1");
      end
   endgenerate

   logic [CW-1:0] count, count_nxt;
   logic          do_pop, do_push, store;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop & ~empty & ~flush;
   assign do_push = push & (~full | do_pop);
   // after a flush the buffer is empty, so a push always lands
   assign store   = flush ? push : do_push;

   always_comb begin
      if (flush) count_nxt = push ? CW'(1) : '0;
      else       count_nxt = count + CW'(do_push) - CW'(do_pop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count_nxt;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (!rst_n)     slot <= '0;
            else if (store) slot <= push_data;
         end
         assign head = slot;
      end else begin : g_ring
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wr_ptr, rd_ptr;
         logic [AW-1:0] wr_slot;

         function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
            return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
         endfunction

         assign wr_slot = flush ? '0 : wr_ptr;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
            end else if (flush) begin
               rd_ptr <= '0;
               wr_ptr <= push ? AW'(1) : '0;
            end else begin
               if (do_push) wr_ptr <= step(wr_ptr);
               if (do_pop)  rd_ptr <= step(rd_ptr);
            end
         end

         always_ff @(posedge clk) begin
            if (store) mem[wr_slot] <= push_data;
         end

         assign head = mem[rd_ptr];
      end
   endgenerate

   // overrun keeps the stored data: no write lands while full and not draining
   p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> ($stable(head) && full));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !push) |=> empty);

endmodule

// File: rtl/midi_cmd_dec.sv
module midi_cmd_dec
   import midi_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_wr,
   input  logic [W-1:0] cmd_byte,
   output port_mode_e   mode,
   output logic         flush_all,
   output logic         ack_push
);
   logic hit_reset, hit_uart;

   assign hit_reset = cmd_wr & (cmd_byte == W'(CMD_RESET));
   assign hit_uart  = cmd_wr & (cmd_byte == W'(CMD_UART));
   assign flush_all = hit_reset;
   assign ack_push  = hit_reset | hit_uart;

   always_ff @(posedge clk) begin
      if (!rst_n)         mode <= MODE_CMD;
      else if (hit_reset) mode <= MODE_CMD;
      else if (hit_uart)  mode <= MODE_UART;
   end

   p_ignore_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_byte != W'(CMD_RESET) && cmd_byte != W'(CMD_UART))
      |=> $stable(mode));

   p_enter_uart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_byte == W'(CMD_UART)) |=> (mode == MODE_UART));

   p_leave_uart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_byte == W'(CMD_RESET)) |=> (mode == MODE_CMD));

endmodule

// File: rtl/midi_port.sv
module midi_port
   import midi_port_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int TX_DEPTH = 2,
   parameter int RX_DEPTH = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_valid,
   input  logic              tx_irq_en,
   input  logic              rx_irq_en,
   output logic              irq_tx_empty,
   output logic              irq_rx_level
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("midi_port: the command protocol is byte wide, DATA_W must be 8");
      end
   endgenerate

   port_mode_e        mode;
   logic              flush_all, ack_push;
   logic              cmd_wr, data_wr, data_rd, in_uart;
   logic              tx_empty, tx_full, tx_pop;
   logic              rx_empty, rx_full, rx_push;
   logic [DATA_W-1:0] rx_head, rx_in, status;

   assign in_uart = (mode == MODE_UART);
   assign cmd_wr  = host_wr & host_sel;
   assign data_wr = host_wr & ~host_sel & in_uart;
   assign data_rd = host_rd & ~host_sel;

   midi_cmd_dec #(.W(DATA_W)) cmd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_byte  (host_wdata),
      .mode      (mode),
      .flush_all (flush_all),
      .ack_push  (ack_push)
   );

   assign tx_pop = tx_ready & ~tx_empty;

   midi_hold_buf #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_buf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_all),
      .push      (data_wr),
      .push_data (host_wdata),
      .pop       (tx_pop),
      .head      (tx_byte),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   // an acknowledge takes the receive write port ahead of a line byte
   assign rx_push = ack_push | (rx_valid & in_uart);
   assign rx_in   = ack_push ? DATA_W'(ACK_BYTE) : rx_byte;

   midi_hold_buf #(.W(DATA_W), .DEPTH(RX_DEPTH)) rx_buf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_all),
      .push      (rx_push),
      .push_data (rx_in),
      .pop       (data_rd),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   always_comb begin
      status = '0;
      status[STAT_RX_EMPTY_BIT] = rx_empty;
      status[STAT_TX_FULL_BIT]  = tx_full;
   end

   assign host_rdata   = host_sel ? status : (rx_empty ? '0 : rx_head);
   assign tx_valid     = ~tx_empty;
   assign irq_tx_empty = tx_irq_en & in_uart & tx_empty;
   assign irq_rx_level = rx_irq_en & ~rx_empty;

   p_cmd_mode_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_uart |-> !tx_valid);

   p_reset_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel && host_wdata == DATA_W'(CMD_RESET))
      |=> (!tx_valid && !rx_empty && rx_head == DATA_W'(ACK_BYTE)));

   p_irq_tx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty |-> !tx_valid);

   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !flush_all) |=> (tx_valid && $stable(tx_byte)));

endmodule

// File: tb/midi_port_tb.sv
`timescale 1ns/1ps
module midi_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic [7:0] tx_byte;
   logic       tx_valid, tx_ready = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_valid = 1'b0;
   logic       tx_irq_en = 1'b1, rx_irq_en = 1'b1;
   logic       irq_tx_empty, irq_rx_level;

   int n_checks = 0, n_fail = 0, tx_xfers = 0;
   logic [7:0] tx_q [$];
   logic [7:0] rx_q [$];
   bit done = 1'b0;

   always #2 clk = ~clk;

   midi_port dut_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_irq_en(tx_irq_en),
      .rx_irq_en(rx_irq_en), .irq_tx_empty(irq_tx_empty), .irq_rx_level(irq_rx_level)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic sel, input logic [7:0] b);
      @(negedge clk);
      host_sel = sel; host_wr = 1'b1; host_wdata = b;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic exp_status(input logic [7:0] exp, input string tag);
      host_sel = 1'b1;
      #1 chk(host_rdata, exp, tag);
   endtask

   task automatic read_data(input string tag);
      logic [7:0] exp;
      @(negedge clk);
      host_sel = 1'b0; host_rd = 1'b1;
      #1;
      if (rx_q.size() == 0) begin
         n_checks++; n_fail++;
         $display("FAIL %s actual=%02h expected=<none queued>", tag, host_rdata);
      end else begin
         exp = rx_q.pop_front();
         chk(host_rdata, exp, tag);
      end
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic line_in(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // scoreboard monitor for the line transmit side
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && tx_valid && tx_ready) begin
            tx_xfers++;
            if (tx_q.size() == 0) begin
               n_checks++; n_fail++;
               $display("FAIL R6 actual=%02h expected=<no byte expected>", tx_byte);
            end else begin
               chk(tx_byte, tx_q.pop_front(), "R6 transmit order");
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R10: reset state
      exp_status(8'h80, "R1 status after reset");
      chk({7'd0, tx_valid}, 8'h00, "R1 tx_valid after reset");
      chk({6'd0, irq_tx_empty, irq_rx_level}, 8'h00, "R1 irqs after reset");

      // R4: unknown command ignored
      host_write(1'b1, 8'h12);
      exp_status(8'h80, "R4 unknown command queues nothing");
      // R5: data write in command mode discarded
      host_write(1'b0, 8'h55);
      chk({7'd0, tx_valid}, 8'h00, "R5 data write in command mode");
      // R8: line byte ignored in command mode
      line_in(8'h33);
      exp_status(8'h80, "R8 line byte ignored in command mode");

      // R2: reset command from command mode
      host_write(1'b1, 8'hFF);
      exp_status(8'h00, "R10 ack waiting clears bit 7");
      chk({7'd0, irq_rx_level}, 8'h01, "R11 rx irq with data");
      rx_q.push_back(8'hFE);
      read_data("R2 reset acknowledge");
      exp_status(8'h80, "R10 status after ack read");

      // R3: enter UART mode
      host_write(1'b1, 8'h3F);
      rx_q.push_back(8'hFE);
      read_data("R3 enter acknowledge");
      chk({7'd0, irq_tx_empty}, 8'h01, "R11 tx irq in UART mode, empty");

      // R7: fill transmit buffer with line stalled
      tx_ready = 1'b0;
      host_write(1'b0, 8'hA1); tx_q.push_back(8'hA1);
      host_write(1'b0, 8'hA2); tx_q.push_back(8'hA2);
      exp_status(8'hC0, "R7 full flag set");
      chk({7'd0, irq_tx_empty}, 8'h00, "R11 tx irq low with data");
      host_write(1'b0, 8'hA3);  // dropped
      base = tx_xfers;
      @(negedge clk); tx_ready = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      chk(8'(tx_xfers - base), 8'd2, "R7 write while full dropped");
      chk(8'(tx_q.size()), 8'd0, "R6 all bytes sent");
      exp_status(8'h80, "R7 full flag clear after drain");

      // R3: repeated enter command keeps UART mode
      host_write(1'b1, 8'h3F);
      rx_q.push_back(8'hFE);
      tx_q.push_back(8'hB1);
      host_write(1'b0, 8'hB1);
      repeat (3) @(negedge clk);
      #1 chk(8'(tx_q.size()), 8'd0, "R3 still in UART after repeat");
      read_data("R3 repeated enter acknowledge");

      // R9: overrun keeps the first byte
      line_in(8'h90);
      line_in(8'h91);
      exp_status(8'h00, "R10 line byte waiting");
      rx_q.push_back(8'h90);
      read_data("R9 overrun keeps unread byte");
      exp_status(8'h80, "R9 newer byte was dropped");
      line_in(8'h92);
      rx_q.push_back(8'h92);
      read_data("R8 line byte read back");

      // R2: reset command in UART mode flushes pending transmit
      tx_ready = 1'b0;
      host_write(1'b0, 8'hC1);
      host_write(1'b1, 8'hFF);
      chk({7'd0, tx_valid}, 8'h00, "R2 reset flushes transmit");
      tx_ready = 1'b1;
      rx_q.push_back(8'hFE);
      read_data("R2 reset acknowledge from UART");
      host_write(1'b0, 8'hD1);
      repeat (2) @(negedge clk);
      #1 chk({7'd0, tx_valid}, 8'h00, "R5 data discarded after reset");
      chk({7'd0, irq_tx_empty}, 8'h00, "R11 tx irq low in command mode");

      // R11: receive irq enable gating
      rx_irq_en = 1'b0;
      host_write(1'b1, 8'hFF);
      #1 chk({7'd0, irq_rx_level}, 8'h00, "R11 rx irq disabled");
      rx_irq_en = 1'b1;
      #1 chk({7'd0, irq_rx_level}, 8'h01, "R11 rx irq enabled");
      rx_q.push_back(8'hFE);
      read_data("R2 ack under irq test");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule